// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Controller

This block produces pulse-width modulated outputs on a parameterised number of channels. All channels share one prescaler, one period counter and one global run bit, so they all run at the same period. Each channel has its own duty value. The period is always 256 local ticks long. One local tick lasts (prescale + 1) input clock cycles, so the prescale value is the only way to change the period.

Software sets up the block through a small 32-bit register bus with an address, a write strobe, write data and combinational read data. The control word holds the 8-bit prescale value, split across two nibbles, and the run bit. A separate register holds a stored interrupt-enable flag. Duty values and the prescale value are captured into shadow copies only at a period boundary, or at any time while the block is stopped. Because of this, an output never shows a partly updated period.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads zero and every output is low.
- R2: The control register is at byte offset 0x50 and keeps only bits [3:0] (prescale low nibble), bit 9 (run) and bits [14:11] (prescale high nibble). The register at 0x54 keeps only bit 0. Channel n's duty register is at byte offset 4·n and keeps bits [7:0]. Bits that are not kept read back as zero.
- R3: Addresses that map to no register, including duty offsets of channels that do not exist, read as zero. Writes to them change no register and no output.
- R4: One period lasts 256 local ticks, and one local tick lasts (prescale + 1) clock cycles. The period counter advances by one on each tick, wraps from 255 to 0, and holds its value between ticks.
- R5: A channel with duty value d is high for the first d + 1 ticks of each period and low for the rest. A duty of 255 keeps the output high for the whole period. All outputs are high while the period counter is 0.
- R6: While the run bit is 0, all outputs are low, and the prescale and period counters are cleared by the next clock edge. Setting the run bit starts a fresh period with the outputs high in the first cycle after the write.
- R7: A duty value written while the block is running takes effect at the start of the next period. The rest of the current period uses the old value.
- R8: A prescale value written while the block is running takes effect at the start of the next period.
- R9: Channels keep their own duty values but share one period and one phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with four channels, while the default is one. With four channels, duty registers at different offsets can hold different values, so R9's shared phase can be checked together with independent duties. The address just past the last channel, 0x10, becomes a real unmapped duty slot for R3. The prescale values used are 0 to 3, so each measured period lasts 256 to 1024 cycles. This exercises the tick spacing of R4 and keeps the run short. The counter and duty widths stay at 8 bits, which puts the constant-high case at 255 and the wrap at 255 to 0 within reach.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int DATA_W     = 32;
   localparam int MAX_CH     = 16;
   localparam int PS_W       = 8;
   localparam int PS_LO_LSB  = 0;
   localparam int PS_HI_LSB  = 11;
   localparam int RUN_BIT    = 9;
   localparam int CTRL_OFS   = 'h50;
   localparam int IRQ_OFS    = 'h54;
   localparam logic [DATA_W-1:0] CTRL_MASK =
      (32'hF << PS_LO_LSB) | (32'hF << PS_HI_LSB) | (32'h1 << RUN_BIT);
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pkg::*;
#(
   parameter int NUM_CH = 1,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_we,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    run_q,
   output logic [PS_W-1:0]         ps_nxt,
   output logic [NUM_CH*CNT_W-1:0] duty_nxt
);
   logic [DATA_W-1:0] ctrl_q, ctrl_d;
   logic              irq_q;
   logic [CNT_W-1:0]  duty_q [NUM_CH];

   wire hit_ctrl = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
   wire hit_irq  = bus_we && (bus_addr == ADDR_W'(IRQ_OFS));

   assign ctrl_d = hit_ctrl ? (bus_wdata & CTRL_MASK) : ctrl_q;
   assign ps_nxt = {ctrl_d[PS_HI_LSB+3:PS_HI_LSB], ctrl_d[PS_LO_LSB+3:PS_LO_LSB]};
   assign run_q  = ctrl_q[RUN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         ctrl_q <= ctrl_d;
         if (hit_irq) irq_q <= bus_wdata[0];
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
      wire hit_duty = bus_we && (bus_addr == ADDR_W'(4 * g));
      wire [CNT_W-1:0] d_val = hit_duty ? bus_wdata[CNT_W-1:0] : duty_q[g];
      assign duty_nxt[g*CNT_W +: CNT_W] = d_val;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) duty_q[g] <= '0;
         else        duty_q[g] <= d_val;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_OFS)) bus_rdata = ctrl_q;
      if (bus_addr == ADDR_W'(IRQ_OFS))  bus_rdata = {{(DATA_W-1){1'b0}}, irq_q};
      for (int i = 0; i < NUM_CH; i++)
         if (bus_addr == ADDR_W'(4 * i)) bus_rdata = DATA_W'(duty_q[i]);
   end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_q,
   input  logic [PS_W-1:0]  ps_nxt,
   output logic [CNT_W-1:0] cnt_q,
   output logic             tick,
   output logic             wrap,
   output logic             load
);
   logic [PS_W-1:0] ps_cnt_q, ps_act_q;

   assign tick = run_q && (ps_cnt_q == ps_act_q);
   assign wrap = tick && (cnt_q == {CNT_W{1'b1}});
   assign load = !run_q || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_cnt_q <= '0;
         ps_act_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (load) ps_act_q <= ps_nxt;
         if (!run_q) begin
            ps_cnt_q <= '0;
            cnt_q    <= '0;
         end else if (tick) begin
            ps_cnt_q <= '0;
            cnt_q    <= cnt_q + 1'b1;
         end else begin
            ps_cnt_q <= ps_cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_q,
   input  logic             load,
   input  logic [CNT_W-1:0] duty_nxt,
   input  logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] duty_act,
   output logic             pwm
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    duty_act <= '0;
      else if (load) duty_act <= duty_nxt;
   end

   assign pwm = run_q && (cnt_q <= duty_act);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_pkg::*;
#(
   parameter int NUM_CH = 1,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("pwm_bank: NUM_CH out of range");
   end
   if (CNT_W != 8) begin : g_bad_cnt
      $error("pwm_bank: CNT_W must be 8");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too small for register map");
   end

   logic                    run_q, tick, wrap, load;
   logic [PS_W-1:0]         ps_nxt;
   logic [CNT_W-1:0]        cnt_q;
   logic [NUM_CH*CNT_W-1:0] duty_nxt, duty_act_flat;

   pwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_q(run_q),
      .ps_nxt(ps_nxt), .duty_nxt(duty_nxt)
   );

   pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run_q(run_q), .ps_nxt(ps_nxt),
      .cnt_q(cnt_q), .tick(tick), .wrap(wrap), .load(load)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .run_q(run_q), .load(load),
         .duty_nxt(duty_nxt[g*CNT_W +: CNT_W]), .cnt_q(cnt_q),
         .duty_act(duty_act_flat[g*CNT_W +: CNT_W]), .pwm(pwm_out[g])
      );
   end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int NUM_CH = 1,
   parameter int CNT_W  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    run_q,
   input logic                    tick,
   input logic                    wrap,
   input logic [CNT_W-1:0]        cnt_q,
   input logic [NUM_CH*CNT_W-1:0] duty_act_flat,
   input logic [NUM_CH-1:0]       pwm_out
);
   wire [CNT_W-1:0] cnt_inc = cnt_q + 1'b1;

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> pwm_out == '0);                                       // R6
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> cnt_q == '0);                                         // R6
   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q == '0) |-> pwm_out == '1);                       // R5
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick) |=> cnt_q == $past(cnt_inc));                    // R4
   AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick) |=> $stable(cnt_q));                            // R4
   AST_DUTY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !wrap) |=> $stable(duty_act_flat));                    // R7

   for (genvar g = 0; g < NUM_CH; g++) begin : g_last
      AST_LAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         (run_q && cnt_q == '1) |->
            pwm_out[g] == (duty_act_flat[g*CNT_W +: CNT_W] == '1));    // R5
   end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run_q), .tick(tick), .wrap(wrap),
   .cnt_q(cnt_q), .duty_act_flat(duty_act_flat), .pwm_out(pwm_out)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
   localparam int NCH = 4;
   localparam logic [7:0] A_CTRL = 8'h50;
   localparam logic [7:0] A_IRQ  = 8'h54;
   localparam logic [7:0] A_NONE = 8'h80;
   // {prescale, duty of channel 0}
   localparam logic [15:0] VEC [6] = '{
      16'h00_00, 16'h00_FF, 16'h00_7F, 16'h01_03, 16'h02_C8, 16'h03_40 };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      bus_addr = A_NONE;
   logic            bus_we = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCH-1:0]  pwm_out;

   int total = 0;
   int bad = 0;
   int hi [NCH];
   int s0 [NCH];

   always #4 clk = ~clk;

   pwm_bank #(.NUM_CH(NCH), .CNT_W(8), .ADDR_W(8)) i_pwm_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   initial for (int i = 0; i < NCH; i++) hi[i] = 0;
   always @(posedge clk)
      for (int i = 0; i < NCH; i++) hi[i] <= hi[i] + int'(pwm_out[i]);

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = A_NONE;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, int'(bus_rdata), int'(exp));
      bus_addr = A_NONE;
   endtask

   function automatic logic [31:0] ctrl_word(input logic run, input logic [7:0] p);
      return (32'(run) << 9) | 32'(p[3:0]) | (32'(p[7:4]) << 11);
   endfunction

   task automatic snap();
      for (int i = 0; i < NCH; i++) s0[i] = hi[i];
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 outputs", int'(pwm_out), 0);
      rd("R1 ctrl", A_CTRL, 0);
      rd("R1 irq", A_IRQ, 0);
      rd("R1 duty0", 8'h00, 0);
      rd("R1 duty3", 8'h0C, 0);

      // R2 field masks and readback
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd("R2 ctrl mask", A_CTRL, 32'h0000_7A0F);
      wr(A_CTRL, 32'h0);
      wr(8'h08, 32'hFFFF_FFFF);
      rd("R2 duty mask", 8'h08, 32'hFF);
      wr(8'h04, 32'h0000_1234);
      rd("R2 duty1", 8'h04, 32'h34);
      wr(A_IRQ, 32'hFFFF_FFFF);
      rd("R2 irq set", A_IRQ, 1);
      wr(A_IRQ, 32'h0);
      rd("R2 irq clear", A_IRQ, 0);

      // R3 unmapped addresses
      wr(8'h10, 32'hAB);
      rd("R3 read 0x10", 8'h10, 0);
      wr(8'h58, 32'hFFFF_FFFF);
      rd("R3 read 0x58", 8'h58, 0);
      rd("R3 read 0x51", 8'h51, 0);
      rd("R3 duty0 kept", 8'h00, 0);
      rd("R3 ctrl kept", A_CTRL, 0);
      check("R3 outputs", int'(pwm_out), 0);

      // Vector table: R4 period, R5 high time, R9 channel independence
      foreach (VEC[v]) begin
         logic [7:0] p, d;
         int n;
         p = VEC[v][15:8];
         d = VEC[v][7:0];
         n = 256 * (int'(p) + 1);
         wr(A_CTRL, 32'h0);
         wr(8'h00, 32'(d));
         wr(8'h04, 32'(8'hFF - d));
         wr(8'h08, 32'(d >> 1));
         wr(8'h0C, 32'hFF);
         wr(A_CTRL, ctrl_word(1'b1, p));
         snap();
         repeat (n) @(negedge clk);
         check("R4 R5 ch0", hi[0] - s0[0], (int'(d) + 1) * (int'(p) + 1));
         check("R9 ch1", hi[1] - s0[1], (256 - int'(d)) * (int'(p) + 1));
         check("R9 ch2", hi[2] - s0[2], (int'(d >> 1) + 1) * (int'(p) + 1));
         check("R5 ch3 full", hi[3] - s0[3], n);
         check("R4 next period high", int'(pwm_out[0]), 1);
      end

      // R7 duty change mid-period
      wr(A_CTRL, 32'h0);
      wr(8'h00, 32'd10);
      wr(A_CTRL, ctrl_word(1'b1, 8'd0));
      snap();
      repeat (50) @(negedge clk);
      wr(8'h00, 32'd100);
      repeat (205) @(negedge clk);
      check("R7 old duty kept", hi[0] - s0[0], 11);
      snap();
      repeat (256) @(negedge clk);
      check("R7 new duty applied", hi[0] - s0[0], 101);

      // R8 prescale change mid-period
      wr(A_CTRL, 32'h0);
      wr(8'h00, 32'd0);
      wr(A_CTRL, ctrl_word(1'b1, 8'd0));
      snap();
      repeat (30) @(negedge clk);
      wr(A_CTRL, ctrl_word(1'b1, 8'd1));
      repeat (225) @(negedge clk);
      check("R8 old prescale kept", hi[0] - s0[0], 1);
      check("R8 period edge", int'(pwm_out[0]), 1);
      snap();
      repeat (512) @(negedge clk);
      check("R8 new prescale ch0", hi[0] - s0[0], 2);
      check("R8 new prescale ch3", hi[3] - s0[3], 512);

      // R6 stop and restart
      wr(A_CTRL, 32'h0);
      check("R6 low after stop", int'(pwm_out), 0);
      snap();
      repeat (300) @(negedge clk);
      check("R6 held low ch3", hi[3] - s0[3], 0);
      wr(A_CTRL, ctrl_word(1'b1, 8'd0));
      check("R6 restart high", int'(pwm_out), 4'hF);
      @(negedge clk);
      check("R6 restart ch0 drops", int'(pwm_out[0]), 0);

      summary();
      $finish;
   end
endmodule